// File: doc/BRIEF.md
# Fairness-Aware DRAM Request Scheduler

This block picks at most one request per memory cycle out of a shared request buffer that several hardware threads fill. Each buffer slot presents a valid flag, a ready flag (already computed upstream against DRAM timing), an owning thread, a target bank, a target row and an age, where a larger age means an older request. The block also sees which row is open in each bank, a slowdown estimate per thread, a weight per thread and an unfairness limit. It returns the index of the chosen slot with a strobe that says a choice was made.

Two orderings are used. In throughput mode, requests that hit an open row go before misses, and older requests go before younger ones. In fairness mode, the requests of the thread whose weighted slowdown is largest go first, then row hits, then age. A mode register is loaded at every clock edge with the result of the unfairness test on that cycle's slowdown inputs. The grant in the following cycle is then made under that stored mode, together with the most-slowed thread captured at the same edge. Slowdown estimation, timing checks and command generation sit outside the block.

Top module: `fair_dram_sched`

## Requirements
- R1: A slot is eligible only when both its valid bit and its ready bit are 1. The granted slot is always eligible.
- R2: When no slot is eligible, `grant_valid` is 0.
- R3: In throughput mode (`fair_mode` = 0), an eligible row hit beats any eligible miss, whatever their ages. A slot is a hit when `bank_open[bank]` is 1 and the row held at `open_row[bank*ROW_W +: ROW_W]` equals the slot's row.
- R4: Among eligible slots that are equal on every higher rule, the one with the larger age wins. When ages are also equal, the lowest slot index wins.
- R5: Weighted slowdown is slowdown × weight. Slowdowns and the limit `unfair_limit` both carry 8 fraction bits. At each clock edge `fair_mode` is loaded with 1 exactly when max_weighted × 256 > `unfair_limit` × min_weighted, and with 0 otherwise. The grant in the next cycle uses that stored value.
- R6: In fairness mode, the slots of the most-slowed thread (the one captured at the same edge as the mode) beat all other slots. Within each group, rules R3 and R4 still apply.
- R7: The most-slowed thread is the one with the highest weighted slowdown. On a tie, the lower thread ID wins. Raising a thread's weight can make it the most-slowed thread and can by itself make the system unfair.
- R8: The mode register and the most-slowed thread are updated even in cycles where no slot is eligible.
- R9: A synchronous active-high reset clears `fair_mode` to 0 and the stored most-slowed thread to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_ENT | Slot holds a request |
| req_ready | input | N_ENT | Slot may issue without a timing violation |
| req_thread | input | N_ENT*TID_W | Owning thread per slot |
| req_bank | input | N_ENT*BANK_W | Target bank per slot |
| req_row | input | N_ENT*ROW_W | Target row per slot |
| req_age | input | N_ENT*AGE_W | Age per slot, larger is older |
| bank_open | input | N_BANK | Bank has an open row |
| open_row | input | N_BANK*ROW_W | Open row per bank |
| slowdown | input | N_THR*SD_W | Slowdown per thread, 8 fraction bits |
| weight | input | N_THR*WT_W | Integer weight per thread |
| unfair_limit | input | AL_W | Tolerated max/min ratio, 8 fraction bits |
| grant_valid | output | 1 | A slot was chosen this cycle |
| grant_idx | output | IDX_W | Index of the chosen slot |
| fair_mode | output | 1 | Stored mode: 1 means fairness ordering |

## Verification
Random buffers use few rows and few age values, so that hit and miss contests and full ties occur often. Slowdowns and weights are drawn from ranges that make the unfairness test flip both ways. Directed cases separate the distinct effects:
- an old miss against a young hit tells row-hit priority apart from age;
- equal slots tell the index tie-break apart;
- a skewed slowdown shows the target thread beating a hit;
- a skewed weight shows that weight alone changes the mode;
- equal top slowdowns show the thread-ID tie-break;
- an empty buffer under skewed slowdowns shows that the mode still updates.

// File: rtl/fsched_pkg.sv
`timescale 1ns/1ps
package fsched_pkg;
    typedef enum logic {
        SCHED_THRUPUT = 1'b0,
        SCHED_FAIR    = 1'b1
    } sched_mode_e;

    localparam int FRAC_BITS = 8;
endpackage

// File: rtl/fsched_mode_unit.sv
`timescale 1ns/1ps
module fsched_mode_unit
    import fsched_pkg::*;
#(
    parameter int N_THR = 4,
    parameter int SD_W  = 16,
    parameter int WT_W  = 4,
    parameter int AL_W  = 16,
    parameter int TID_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_THR*SD_W-1:0]   slowdown,
    input  logic [N_THR*WT_W-1:0]   weight,
    input  logic [AL_W-1:0]         unfair_limit,
    output sched_mode_e             mode_q,
    output logic [TID_W-1:0]        top_q
);
    localparam int WS_W  = SD_W + WT_W;
    localparam int CMP_W = WS_W + AL_W + FRAC_BITS;

    logic [WS_W-1:0]  wsd [N_THR];
    logic [WS_W-1:0]  ws_max, ws_min;
    logic [TID_W-1:0] top_c;
    logic [CMP_W-1:0] lhs, rhs;
    logic             unfair_c;

    for (genvar t = 0; t < N_THR; t++) begin : g_weigh
        assign wsd[t] = {{WT_W{1'b0}}, slowdown[t*SD_W +: SD_W]}
                      * {{SD_W{1'b0}}, weight[t*WT_W +: WT_W]};
    end

    always_comb begin
        ws_max = wsd[0];
        ws_min = wsd[0];
        top_c  = '0;
        for (int t = 1; t < N_THR; t++) begin
            if (wsd[t] > ws_max) begin
                ws_max = wsd[t];
                top_c  = TID_W'(t);
            end
            if (wsd[t] < ws_min) ws_min = wsd[t];
        end
        lhs      = CMP_W'(ws_max) << FRAC_BITS;
        rhs      = CMP_W'(unfair_limit) * CMP_W'(ws_min);
        unfair_c = lhs > rhs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SCHED_THRUPUT;
            top_q  <= '0;
        end else begin
            mode_q <= unfair_c ? SCHED_FAIR : SCHED_THRUPUT;
            top_q  <= top_c;
        end
    end

    // R9: right after reset the stored mode is throughput
    a_r9_reset_mode: assert property (@(posedge clk)
        rst |=> mode_q == SCHED_THRUPUT);
endmodule

// File: rtl/fsched_key_gen.sv
`timescale 1ns/1ps
module fsched_key_gen
    import fsched_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int N_BANK = 4,
    parameter int ROW_W  = 8,
    parameter int AGE_W  = 8,
    parameter int TID_W  = 2,
    parameter int BANK_W = 2,
    parameter int KEY_W  = AGE_W + 3
) (
    input  logic [N_ENT-1:0]         req_valid,
    input  logic [N_ENT-1:0]         req_ready,
    input  logic [N_ENT*TID_W-1:0]   req_thread,
    input  logic [N_ENT*BANK_W-1:0]  req_bank,
    input  logic [N_ENT*ROW_W-1:0]   req_row,
    input  logic [N_ENT*AGE_W-1:0]   req_age,
    input  logic [N_BANK-1:0]        bank_open,
    input  logic [N_BANK*ROW_W-1:0]  open_row,
    input  sched_mode_e              mode,
    input  logic [TID_W-1:0]         top_tid,
    output logic [N_ENT-1:0]         elig,
    output logic [N_ENT-1:0]         hit,
    output logic [N_ENT-1:0]         own,
    output logic [N_ENT*KEY_W-1:0]   key_flat
);
    for (genvar i = 0; i < N_ENT; i++) begin : g_slot
        logic [BANK_W-1:0] bk;
        assign bk      = req_bank[i*BANK_W +: BANK_W];
        assign elig[i] = req_valid[i] & req_ready[i];
        assign hit[i]  = bank_open[bk] &&
                         (open_row[bk*ROW_W +: ROW_W] == req_row[i*ROW_W +: ROW_W]);
        assign own[i]  = (mode == SCHED_FAIR) &&
                         (req_thread[i*TID_W +: TID_W] == top_tid);
        assign key_flat[i*KEY_W +: KEY_W] =
            {elig[i], own[i], hit[i], req_age[i*AGE_W +: AGE_W]};
    end
endmodule

// File: rtl/fsched_pick.sv
`timescale 1ns/1ps
module fsched_pick #(
    parameter int N_ENT = 8,
    parameter int KEY_W = 11,
    parameter int IDX_W = 3
) (
    input  logic [N_ENT*KEY_W-1:0] key_flat,
    output logic                   grant_valid,
    output logic [IDX_W-1:0]       grant_idx
);
    logic [KEY_W-1:0] best;

    // strict compare while scanning upward keeps the lowest index on ties
    always_comb begin
        best      = key_flat[KEY_W-1:0];
        grant_idx = '0;
        for (int i = 1; i < N_ENT; i++) begin
            if (key_flat[i*KEY_W +: KEY_W] > best) begin
                best      = key_flat[i*KEY_W +: KEY_W];
                grant_idx = IDX_W'(i);
            end
        end
        grant_valid = best[KEY_W-1];
    end
endmodule

// File: rtl/fair_dram_sched.sv
`timescale 1ns/1ps
module fair_dram_sched
    import fsched_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int N_THR  = 4,
    parameter int N_BANK = 4,
    parameter int ROW_W  = 8,
    parameter int AGE_W  = 8,
    parameter int SD_W   = 16,
    parameter int WT_W   = 4,
    parameter int AL_W   = 16,
    localparam int TID_W  = $clog2(N_THR),
    localparam int BANK_W = $clog2(N_BANK),
    localparam int IDX_W  = $clog2(N_ENT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_ENT-1:0]         req_valid,
    input  logic [N_ENT-1:0]         req_ready,
    input  logic [N_ENT*TID_W-1:0]   req_thread,
    input  logic [N_ENT*BANK_W-1:0]  req_bank,
    input  logic [N_ENT*ROW_W-1:0]   req_row,
    input  logic [N_ENT*AGE_W-1:0]   req_age,
    input  logic [N_BANK-1:0]        bank_open,
    input  logic [N_BANK*ROW_W-1:0]  open_row,
    input  logic [N_THR*SD_W-1:0]    slowdown,
    input  logic [N_THR*WT_W-1:0]    weight,
    input  logic [AL_W-1:0]          unfair_limit,
    output logic                     grant_valid,
    output logic [IDX_W-1:0]         grant_idx,
    output logic                     fair_mode
);
    localparam int KEY_W = AGE_W + 3;

    sched_mode_e            mode_q;
    logic [TID_W-1:0]       top_q;
    logic [N_ENT-1:0]       elig, hit, own;
    logic [N_ENT*KEY_W-1:0] key_flat;

    fsched_mode_unit #(
        .N_THR(N_THR), .SD_W(SD_W), .WT_W(WT_W), .AL_W(AL_W), .TID_W(TID_W)
    ) i_mode (
        .clk(clk), .rst(rst), .slowdown(slowdown), .weight(weight),
        .unfair_limit(unfair_limit), .mode_q(mode_q), .top_q(top_q)
    );

    fsched_key_gen #(
        .N_ENT(N_ENT), .N_BANK(N_BANK), .ROW_W(ROW_W), .AGE_W(AGE_W),
        .TID_W(TID_W), .BANK_W(BANK_W), .KEY_W(KEY_W)
    ) i_keys (
        .req_valid(req_valid), .req_ready(req_ready), .req_thread(req_thread),
        .req_bank(req_bank), .req_row(req_row), .req_age(req_age),
        .bank_open(bank_open), .open_row(open_row), .mode(mode_q),
        .top_tid(top_q), .elig(elig), .hit(hit), .own(own), .key_flat(key_flat)
    );

    fsched_pick #(
        .N_ENT(N_ENT), .KEY_W(KEY_W), .IDX_W(IDX_W)
    ) i_pick (
        .key_flat(key_flat), .grant_valid(grant_valid), .grant_idx(grant_idx)
    );

    assign fair_mode = (mode_q == SCHED_FAIR);

    // R1: only a valid and ready slot is granted
    a_r1_grant_eligible: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (req_valid[grant_idx] && req_ready[grant_idx]));

    // R2: no eligible slot, no grant
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (~|(req_valid & req_ready)) |-> !grant_valid);

    // R3: throughput mode never passes over an eligible hit
    a_r3_hit_first: assert property (@(posedge clk) disable iff (rst)
        (!fair_mode && |(elig & hit)) |-> hit[grant_idx]);

    // R6: fairness mode never passes over the slowed thread
    a_r6_slowed_first: assert property (@(posedge clk) disable iff (rst)
        (fair_mode && |(elig & own)) |-> own[grant_idx]);
endmodule

// File: tb/test_fair_dram_sched.sv
`timescale 1ns/1ps
module test_fair_dram_sched;
    localparam int N_ENT = 8, N_THR = 4, N_BANK = 4, ROW_W = 8, AGE_W = 8;
    localparam int SD_W = 16, WT_W = 4, AL_W = 16;
    localparam int TID_W = 2, BANK_W = 2, IDX_W = 3;

    logic clk = 0;
    logic rst = 1;
    logic [N_ENT-1:0]        req_valid = '0, req_ready = '0;
    logic [N_ENT*TID_W-1:0]  req_thread = '0;
    logic [N_ENT*BANK_W-1:0] req_bank = '0;
    logic [N_ENT*ROW_W-1:0]  req_row = '0;
    logic [N_ENT*AGE_W-1:0]  req_age = '0;
    logic [N_BANK-1:0]       bank_open = '0;
    logic [N_BANK*ROW_W-1:0] open_row = '0;
    logic [N_THR*SD_W-1:0]   slowdown = '0;
    logic [N_THR*WT_W-1:0]   weight = '0;
    logic [AL_W-1:0]         unfair_limit = '0;
    logic                    grant_valid, fair_mode;
    logic [IDX_W-1:0]        grant_idx;

    int n_chk = 0, n_bad = 0;
    bit exp_mode = 0;
    int exp_top = 0;

    always #4 clk = ~clk;

    fair_dram_sched i_fair_dram_sched (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_thread(req_thread), .req_bank(req_bank), .req_row(req_row),
        .req_age(req_age), .bank_open(bank_open), .open_row(open_row),
        .slowdown(slowdown), .weight(weight), .unfair_limit(unfair_limit),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .fair_mode(fair_mode)
    );

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint wsd(int t);
        return longint'(slowdown[t*SD_W +: SD_W]) * longint'(weight[t*WT_W +: WT_W]);
    endfunction

    function automatic bit ref_unfair();
        longint mx = wsd(0), mn = wsd(0);
        for (int t = 1; t < N_THR; t++) begin
            if (wsd(t) > mx) mx = wsd(t);
            if (wsd(t) < mn) mn = wsd(t);
        end
        return (mx * 256) > (longint'(unfair_limit) * mn);
    endfunction

    function automatic int ref_top();
        int b = 0;
        for (int t = 1; t < N_THR; t++) if (wsd(t) > wsd(b)) b = t;
        return b;
    endfunction

    function automatic bit is_hit(int i);
        int bk = int'(req_bank[i*BANK_W +: BANK_W]);
        return bank_open[bk] && open_row[bk*ROW_W +: ROW_W] == req_row[i*ROW_W +: ROW_W];
    endfunction

    // 1 when slot a must win over slot b
    function automatic bit beats(int a, int b);
        bit oa, ob;
        int ga, gb;
        oa = exp_mode && int'(req_thread[a*TID_W +: TID_W]) == exp_top;
        ob = exp_mode && int'(req_thread[b*TID_W +: TID_W]) == exp_top;
        if (oa != ob) return oa;
        if (is_hit(a) != is_hit(b)) return is_hit(a);
        ga = int'(req_age[a*AGE_W +: AGE_W]);
        gb = int'(req_age[b*AGE_W +: AGE_W]);
        if (ga != gb) return ga > gb;
        return a < b;
    endfunction

    function automatic int ref_grant();
        int w = -1;
        for (int i = 0; i < N_ENT; i++)
            if (req_valid[i] && req_ready[i])
                if (w < 0 || beats(i, w)) w = i;
        return w;
    endfunction

    task automatic set_slot(int i, bit v, bit r, int tid, int bk, int row, int age);
        req_valid[i] = v;
        req_ready[i] = r;
        req_thread[i*TID_W +: TID_W] = TID_W'(tid);
        req_bank[i*BANK_W +: BANK_W] = BANK_W'(bk);
        req_row[i*ROW_W +: ROW_W]    = ROW_W'(row);
        req_age[i*AGE_W +: AGE_W]    = AGE_W'(age);
    endtask

    task automatic set_thr(int t, int sd, int wt);
        slowdown[t*SD_W +: SD_W] = SD_W'(sd);
        weight[t*WT_W +: WT_W]   = WT_W'(wt);
    endtask

    task automatic balanced();
        for (int t = 0; t < N_THR; t++) set_thr(t, 256, 1);
        unfair_limit = 16'd512;
        req_valid = '0;
        req_ready = '0;
    endtask

    // inputs are already driven after a negedge; check, then let the edge pass
    task automatic evaluate(string tag);
        int g;
        #1;
        g = ref_grant();
        check({tag, " grant_valid"}, grant_valid, g >= 0);
        if (g >= 0) check({tag, " grant_idx"}, grant_idx, g);
        check("R5 fair_mode", fair_mode, exp_mode);
        @(posedge clk);
        exp_mode = ref_unfair();
        exp_top  = ref_top();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20071));
        balanced();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R9 reset fair_mode", fair_mode, 0);

        // R1: valid without ready, ready without valid
        req_valid = '1; req_ready = '0; evaluate("R1 valid-only");
        req_valid = '0; req_ready = '1; evaluate("R1 ready-only");
        // R2: empty buffer
        balanced(); evaluate("R2 empty");

        // R3: young hit against old miss
        bank_open = 4'b0100; open_row[2*ROW_W +: ROW_W] = 8'd7;
        set_slot(2, 1, 1, 0, 2, 3, 200);
        set_slot(5, 1, 1, 1, 2, 7, 1);
        evaluate("R3 hit over older miss");

        // R4: equal misses, then the older one
        balanced(); bank_open = '0;
        set_slot(3, 1, 1, 0, 1, 1, 10);
        set_slot(6, 1, 1, 1, 1, 1, 10);
        evaluate("R4 index tie");
        set_slot(6, 1, 1, 1, 1, 1, 11);
        evaluate("R4 older wins");

        // R6: skewed slowdown, target thread beats a hit
        balanced(); set_thr(2, 1024, 1);
        bank_open = 4'b0001; open_row[0 +: ROW_W] = 8'd4;
        set_slot(0, 1, 1, 0, 0, 4, 255);
        set_slot(1, 1, 1, 2, 3, 9, 0);
        evaluate("R6 prep");
        evaluate("R6 slowed thread first");

        // R7: weight alone makes thread 3 the target
        for (int t = 0; t < N_THR; t++) set_thr(t, 256, 1);
        set_thr(3, 256, 3);
        set_slot(1, 1, 1, 3, 3, 9, 0);
        evaluate("R7 weight prep");
        evaluate("R7 weight picks thread");
        // R7: tie on slowdown goes to lower thread ID
        set_thr(3, 256, 1); set_thr(1, 1024, 1); set_thr(2, 1024, 1);
        set_slot(0, 1, 1, 2, 3, 9, 50);
        set_slot(1, 1, 1, 1, 3, 9, 0);
        evaluate("R7 tie prep");
        evaluate("R7 lower thread ID");

        // R8: mode follows slowdowns with nothing eligible
        balanced(); evaluate("R8 calm");
        set_thr(0, 2000, 1); evaluate("R8 skew idle");
        evaluate("R8 mode set while idle");

        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < N_ENT; i++)
                set_slot(i, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                         $urandom_range(0, 3), $urandom_range(0, 3),
                         $urandom_range(0, 2), $urandom_range(0, 3));
            bank_open = 4'($urandom);
            for (int b = 0; b < N_BANK; b++) open_row[b*ROW_W +: ROW_W] = 8'($urandom_range(0, 2));
            for (int t = 0; t < N_THR; t++)
                set_thr(t, $urandom_range(0, 20) == 0 ? 0 : $urandom_range(256, 1023),
                        $urandom_range(0, 3));
            unfair_limit = 16'($urandom_range(256, 1024));
            evaluate("R3 R4 R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule